// File: doc/BRIEF.md
# Passive Parallel Configuration Host

This block loads a downstream programmable device over a byte-wide passive configuration link. When `start` is pulsed, it drives the target's active-low configuration-reset line low for a fixed number of system clocks. It then waits for the target to release its active-low status line. After that it takes bytes from a valid/ready stream and places each one on `data`. Each byte is clocked into the target by a rising edge on `dclk`, which the block generates itself. `dclk` only toggles when a byte is ready, so a slow source simply stretches the clock.

When the last byte of the stream has been clocked in, the block expects the target's done line to be high. It then sends a fixed number of extra clock cycles for initialisation and waits for the init-done line. Errors are handled in one of two ways. If the target reports an error by pulling status low, the block can wait for the target's automatic restart, when that mode is enabled. Otherwise, or if any wait times out, the block repeats the whole sequence with a fresh reset pulse. The number of attempts is limited, and the result is reported on `pass` or `fail`. A free-running `usr_clk` output gives the target a clock that keeps running while status is held low.

Each new transfer attempt raises `attempt` for one cycle. The source must then rewind to its first byte, because `s_ready` may accept that byte in the same cycle.

Top module: `ppcfg_host`

## Requirements
- R1: After reset, `cfg_n` is 1 and `dclk`, `pass`, `fail` and `s_ready` are 0.
- R2: A `start` pulse in the idle, pass or fail state drives `cfg_n` low for exactly PULSE_CYC clocks. Every later reset pulse has the same width.
- R3: No byte is accepted and `dclk` does not rise until `status_n` is high after `cfg_n` returns high. In every cycle after one in which `status_n` is sampled low, `dclk` is 0.
- R4: Bytes reach the target in stream order. A byte is stable on `data` for at least DCLK_LO clocks before `dclk` rises, stays stable while `dclk` is high, and `dclk` is high for exactly DCLK_HI clocks.
- R5: While `s_valid` is low, `dclk` stays low for as long as needed, and configuration is not aborted.
- R6: `attempt` is 1 for exactly the first cycle of each transfer attempt. `s_ready` may be 1 in that cycle, and the source must then present byte 0.
- R7: With AUTO_RESTART=1, if status goes low during the transfer and returns high within ERR_WD clocks, the transfer restarts from byte 0 with no new `cfg_n` pulse.
- R8: With AUTO_RESTART=1, if status stays low for ERR_WD clocks after an error, a new `cfg_n` pulse is issued.
- R9: With AUTO_RESTART=0, a status error always leads to a new `cfg_n` pulse.
- R10: A new attempt with a `cfg_n` pulse follows in either of two cases: `conf_done` is low when `dclk` falls after the byte marked `s_last`, or `status_n` is not released within STATUS_WAIT clocks after the pulse.
- R11: After `conf_done`, exactly INIT_CLKS extra `dclk` cycles are sent. `init_done` then sets `pass`. If `init_done` does not arrive within INIT_WAIT clocks, the sequence is retried.
- R12: After MAX_TRIES failed attempts (auto restarts included), `fail` is set. `pass` and `fail` hold until the next `start`.
- R13: `usr_clk` changes level at least once every USR_HALF clocks at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final byte of the stream |
| s_ready | output | 1 | Byte accepted this cycle when valid |
| attempt | output | 1 | First cycle of a transfer attempt; source rewinds |
| cfg_n | output | 1 | Active-low configuration reset to target |
| status_n | input | 1 | Active-low status/error from target |
| conf_done | input | 1 | Target has received all data |
| init_done | input | 1 | Target has finished initialisation |
| dclk | output | 1 | Configuration clock to target |
| data | output | 8 | Configuration byte to target |
| usr_clk | output | 1 | Free-running clock for target initialisation |
| pass | output | 1 | Configuration succeeded |
| fail | output | 1 | Attempts exhausted |

## Verification
The cycle that raises `attempt` after an automatic restart is also a cycle in which the source's first byte can be accepted. A rewind and a handshake can therefore coincide. The bench provokes this by holding a target error low for a short time in auto mode while the source keeps `s_valid` high. When status returns, the restart and the acceptance of byte 0 fall on the same clock. The target model compares every byte it captures against the stream order starting from 0. A run is judged correct only if it ends in `pass`, with no mismatched byte and no extra `cfg_n` pulse.

// File: rtl/ppcfg_host.sv
module ppcfg_host #(
  parameter int PULSE_CYC    = 50,
  parameter int DCLK_HI      = 2,
  parameter int DCLK_LO      = 2,
  parameter int STATUS_WAIT  = 4000,
  parameter int ERR_WD       = 8000,
  parameter int INIT_CLKS    = 8,
  parameter int INIT_WAIT    = 10000,
  parameter int MAX_TRIES    = 3,
  parameter int USR_HALF     = 2,
  parameter bit AUTO_RESTART = 1'b1,
  parameter int CW           = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       attempt,
  output logic       cfg_n,
  input  logic       status_n,
  input  logic       conf_done,
  input  logic       init_done,
  output logic       dclk,
  output logic [7:0] data,
  output logic       usr_clk,
  output logic       pass,
  output logic       fail
);
  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int UW = $clog2(USR_HALF + 1);

  typedef enum logic [3:0] {
    IDLE, PULSE, WREL, XFER, ICLK, WINIT, ERR, OK, BAD
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt, nclk;
  logic [TW-1:0] tries;
  logic [UW-1:0] ucnt;
  logic          have, lastf;
  logic          give_up, redo, err_now, auto_go, cnt0;

  assign cnt0    = (cnt == '0);
  assign give_up = (tries == TW'(MAX_TRIES - 1));
  assign err_now = (st == XFER || st == ICLK || st == WINIT) && !status_n;
  assign auto_go = (st == ERR) && AUTO_RESTART && status_n;
  assign s_ready = (st == XFER) && !have && status_n;
  assign cfg_n   = (st != PULSE);
  assign pass    = (st == OK);
  assign fail    = (st == BAD);

  always_comb begin
    redo = 1'b0;
    case (st)
      WREL:  redo = !status_n && cnt0;
      XFER:  redo = status_n && have && dclk && cnt0 && lastf && !conf_done;
      WINIT: redo = status_n && !init_done && cnt0;
      ERR:   redo = !AUTO_RESTART || (!status_n && cnt0);
      default: redo = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucnt    <= '0;
      usr_clk <= 1'b0;
    end else if (ucnt == UW'(USR_HALF - 1)) begin
      ucnt    <= '0;
      usr_clk <= !usr_clk;
    end else begin
      ucnt <= ucnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      nclk    <= '0;
      tries   <= '0;
      have    <= 1'b0;
      lastf   <= 1'b0;
      dclk    <= 1'b0;
      data    <= '0;
      attempt <= 1'b0;
    end else begin
      attempt <= 1'b0;
      if (redo || auto_go) begin
        dclk <= 1'b0;
        have <= 1'b0;
        if (give_up) begin
          st <= BAD;
        end else begin
          tries <= tries + 1'b1;
          if (auto_go) begin
            st      <= XFER;
            attempt <= 1'b1;
          end else begin
            st  <= PULSE;
            cnt <= CW'(PULSE_CYC - 1);
          end
        end
      end else if (err_now) begin
        st   <= ERR;
        cnt  <= CW'(ERR_WD - 1);
        dclk <= 1'b0;
        have <= 1'b0;
      end else begin
        case (st)
          IDLE, OK, BAD: if (start) begin
            st    <= PULSE;
            cnt   <= CW'(PULSE_CYC - 1);
            tries <= '0;
          end
          PULSE: if (cnt0) begin
            st  <= WREL;
            cnt <= CW'(STATUS_WAIT - 1);
          end else cnt <= cnt - 1'b1;
          WREL: if (status_n) begin
            st      <= XFER;
            attempt <= 1'b1;
            have    <= 1'b0;
          end else cnt <= cnt - 1'b1;
          XFER: begin
            if (!have) begin
              if (s_valid) begin
                data  <= s_data;
                have  <= 1'b1;
                lastf <= s_last;
                cnt   <= CW'(DCLK_LO - 1);
              end
            end else if (!cnt0) begin
              cnt <= cnt - 1'b1;
            end else if (!dclk) begin
              dclk <= 1'b1;
              cnt  <= CW'(DCLK_HI - 1);
            end else begin
              dclk <= 1'b0;
              have <= 1'b0;
              if (lastf) begin
                if (INIT_CLKS == 0) begin
                  st  <= WINIT;
                  cnt <= CW'(INIT_WAIT - 1);
                end else begin
                  st   <= ICLK;
                  nclk <= CW'(INIT_CLKS);
                  cnt  <= CW'(DCLK_LO - 1);
                end
              end
            end
          end
          ICLK: if (!cnt0) begin
            cnt <= cnt - 1'b1;
          end else if (!dclk) begin
            dclk <= 1'b1;
            cnt  <= CW'(DCLK_HI - 1);
          end else begin
            dclk <= 1'b0;
            cnt  <= CW'(DCLK_LO - 1);
            if (nclk == CW'(1)) begin
              st  <= WINIT;
              cnt <= CW'(INIT_WAIT - 1);
            end else nclk <= nclk - 1'b1;
          end
          WINIT: if (init_done) st <= OK;
                 else cnt <= cnt - 1'b1;
          ERR: cnt <= cnt - 1'b1;
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ppcfg_host_chk.sv
module ppcfg_host_chk #(
  parameter int PULSE_CYC = 50,
  parameter int DCLK_HI   = 2,
  parameter int USR_HALF  = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       cfg_n,
  input logic       status_n,
  input logic       dclk,
  input logic [7:0] data,
  input logic       s_ready,
  input logic       init_done,
  input logic       usr_clk,
  input logic       pass,
  input logic       fail
);
  int   lo_run, hi_run, gap;
  logic u_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= 0;
      hi_run <= 0;
      gap    <= 0;
      u_q    <= 1'b0;
    end else begin
      lo_run <= cfg_n ? 0 : lo_run + 1;
      hi_run <= dclk ? hi_run + 1 : 0;
      u_q    <= usr_clk;
      gap    <= (usr_clk != u_q) ? 0 : gap + 1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_n) |-> lo_run == PULSE_CYC);

  // R3
  dclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_n |=> !dclk);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $stable(data));

  // R4
  clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dclk) |-> hi_run == DCLK_HI);

  // R3
  ready_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !dclk && cfg_n);

  // R11
  pass_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(init_done));

  // R12
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail);

  // R12
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass && !start |=> pass);

  // R13
  usr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= USR_HALF);
endmodule

bind ppcfg_host ppcfg_host_chk #(
  .PULSE_CYC(PULSE_CYC), .DCLK_HI(DCLK_HI), .USR_HALF(USR_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_n(cfg_n), .status_n(status_n),
  .dclk(dclk), .data(data), .s_ready(s_ready), .init_done(init_done),
  .usr_clk(usr_clk), .pass(pass), .fail(fail)
);

// File: tb/sim_models.sv
module tgt_model (
  input  logic       clk,
  input  logic       clr,
  input  logic       cfg_n,
  input  logic       dclk,
  input  logic [7:0] data,
  input  int         nbytes,
  input  int         err_at,
  input  int         err_hold,
  input  int         rel_dly,
  input  logic       no_done,
  input  int         init_need,
  output logic       status_n,
  output logic       conf_done,
  output logic       init_done,
  output int         pulses,
  output int         bytes,
  output int         bad,
  output int         post,
  output int         hold_bad,
  output int         ovl_bad
);
  logic       dq = 1'b0, cq = 1'b1, armed = 1'b1;
  logic [7:0] data_q = '0;
  int         rel = 0;
  logic       rise;

  initial begin
    status_n = 1'b1; conf_done = 1'b0; init_done = 1'b0;
    pulses = 0; bytes = 0; bad = 0; post = 0; hold_bad = 0; ovl_bad = 0;
  end

  assign rise = dclk && !dq;

  always @(posedge clk) begin
    dq     <= dclk;
    cq     <= cfg_n;
    data_q <= data;
    if (clr) begin
      pulses <= 0; bad <= 0; hold_bad <= 0; ovl_bad <= 0; armed <= 1'b1;
    end else begin
      if (cq && !cfg_n) pulses <= pulses + 1;
      if (rise && (!status_n || !cfg_n)) ovl_bad <= ovl_bad + 1;
      if (rise && data != data_q) hold_bad <= hold_bad + 1;
    end
    if (!cfg_n) begin
      status_n <= 1'b0; conf_done <= 1'b0; init_done <= 1'b0;
      bytes <= 0; post <= 0; rel <= rel_dly;
    end else if (!status_n) begin
      if (rel > 0) rel <= rel - 1;
      else begin
        status_n <= 1'b1; bytes <= 0; conf_done <= 1'b0; post <= 0;
      end
    end else if (rise) begin
      if (!conf_done) begin
        if (data != 8'(bytes * 37 + 11)) bad <= bad + 1;
        bytes <= bytes + 1;
        if (armed && bytes == err_at) begin
          armed    <= 1'b0;
          status_n <= 1'b0;
          rel      <= err_hold;
        end else if (bytes == nbytes - 1 && !no_done) conf_done <= 1'b1;
      end else begin
        post <= post + 1;
        if (post + 1 >= init_need) init_done <= 1'b1;
      end
    end
  end
endmodule

module src_model (
  input  logic       clk,
  input  logic       attempt,
  input  logic       s_ready,
  input  int         nbytes,
  input  logic       gaps,
  output logic [7:0] s_data,
  output logic       s_valid,
  output logic       s_last
);
  int idx = 0;
  int cyc = 0;
  int eidx;
  assign eidx    = attempt ? 0 : idx;
  assign s_data  = 8'(eidx * 37 + 11);
  assign s_valid = (eidx < nbytes) && !(gaps && (cyc % 5 != 0));
  assign s_last  = (eidx == nbytes - 1);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (s_valid && s_ready) idx <= eidx + 1;
    else if (attempt) idx <= 0;
  end
endmodule

// File: tb/sim_ppcfg_host.sv
module sim_ppcfg_host;
  localparam int PC = 50, HI = 2, LO = 2, SW = 300, WD = 200, IC = 4, IW = 100;
  localparam int MT = 3, UH = 3, N = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = !clk;

  logic start0 = 1'b0, start1 = 1'b0, clr = 1'b0;
  int nb = N, err_at = -1, err_hold = 0, rel_dly = 10, init_need = 2;
  logic no_done = 1'b0, gaps = 1'b0;

  logic [7:0] sd0, sd1, d0, d1;
  logic sv0, sv1, sl0, sl1, rd0, rd1, at0, at1, cf0, cf1, st0, st1;
  logic cd0, cd1, id0, id1, dc0, dc1, uc0, uc1, ps0, ps1, fl0, fl1;
  int pu0, by0, bd0, po0, hb0, ob0, pu1, by1, bd1, po1, hb1, ob1;

  ppcfg_host #(.PULSE_CYC(PC), .DCLK_HI(HI), .DCLK_LO(LO), .STATUS_WAIT(SW),
    .ERR_WD(WD), .INIT_CLKS(IC), .INIT_WAIT(IW), .MAX_TRIES(MT), .USR_HALF(UH),
    .AUTO_RESTART(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .s_data(sd0), .s_valid(sv0),
    .s_last(sl0), .s_ready(rd0), .attempt(at0), .cfg_n(cf0), .status_n(st0),
    .conf_done(cd0), .init_done(id0), .dclk(dc0), .data(d0), .usr_clk(uc0),
    .pass(ps0), .fail(fl0));

  ppcfg_host #(.PULSE_CYC(PC), .DCLK_HI(HI), .DCLK_LO(LO), .STATUS_WAIT(SW),
    .ERR_WD(WD), .INIT_CLKS(IC), .INIT_WAIT(IW), .MAX_TRIES(MT), .USR_HALF(UH),
    .AUTO_RESTART(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start1), .s_data(sd1), .s_valid(sv1),
    .s_last(sl1), .s_ready(rd1), .attempt(at1), .cfg_n(cf1), .status_n(st1),
    .conf_done(cd1), .init_done(id1), .dclk(dc1), .data(d1), .usr_clk(uc1),
    .pass(ps1), .fail(fl1));

  src_model s0 (.clk(clk), .attempt(at0), .s_ready(rd0), .nbytes(nb), .gaps(gaps),
    .s_data(sd0), .s_valid(sv0), .s_last(sl0));
  src_model s1 (.clk(clk), .attempt(at1), .s_ready(rd1), .nbytes(nb), .gaps(gaps),
    .s_data(sd1), .s_valid(sv1), .s_last(sl1));

  tgt_model t0 (.clk(clk), .clr(clr), .cfg_n(cf0), .dclk(dc0), .data(d0), .nbytes(nb),
    .err_at(err_at), .err_hold(err_hold), .rel_dly(rel_dly), .no_done(no_done),
    .init_need(init_need), .status_n(st0), .conf_done(cd0), .init_done(id0),
    .pulses(pu0), .bytes(by0), .bad(bd0), .post(po0), .hold_bad(hb0), .ovl_bad(ob0));
  tgt_model t1 (.clk(clk), .clr(clr), .cfg_n(cf1), .dclk(dc1), .data(d1), .nbytes(nb),
    .err_at(err_at), .err_hold(err_hold), .rel_dly(rel_dly), .no_done(no_done),
    .init_need(init_need), .status_n(st1), .conf_done(cd1), .init_done(id1),
    .pulses(pu1), .bytes(by1), .bad(bd1), .post(po1), .hold_bad(hb1), .ovl_bad(ob1));

  int compared = 0, mismatched = 0, cycles = 0;
  int lo = 0, lo_bad = 0, hi = 0, hi_bad = 0, gap = 0, usr_bad = 0, att_cnt = 0;
  logic uq = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (!cf0) lo <= lo + 1;
      else begin
        if (lo != 0 && lo != PC) lo_bad <= lo_bad + 1;
        lo <= 0;
      end
      if (dc0) hi <= hi + 1;
      else begin
        if (hi != 0 && hi != HI) hi_bad <= hi_bad + 1;
        hi <= 0;
      end
      uq <= uc0;
      if (uc0 != uq) gap <= 0;
      else begin
        gap <= gap + 1;
        if (gap + 1 > UH) usr_bad <= usr_bad + 1;
      end
      if (clr) att_cnt <= 0;
      else if (at0) att_cnt <= att_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input bit which);
    int n;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    if (which) start1 = 1'b1; else start0 = 1'b1;
    @(negedge clk); start0 = 1'b0; start1 = 1'b0;
    n = 0;
    while (!(which ? (ps1 || fl1) : (ps0 || fl0)) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(n < 20000, "watchdog", n, 20000);
  endtask

  task automatic defaults();
    err_at = -1; err_hold = 0; rel_dly = 10; init_need = 2;
    no_done = 1'b0; gaps = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cf0 == 1'b1, "R1 cfg_n", cf0, 1);
    chk(dc0 == 1'b0 && rd0 == 1'b0, "R1 dclk/ready", {dc0, rd0}, 0);
    chk(ps0 == 1'b0 && fl0 == 1'b0, "R1 pass/fail", {ps0, fl0}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    defaults(); run(0);
    chk(ps0 == 1'b1, "R11 pass", ps0, 1);
    chk(pu0 == 1, "R2 pulses", pu0, 1);
    chk(by0 == N && bd0 == 0, "R4 byte order", bd0, 0);
    chk(hb0 == 0 && hi_bad == 0, "R4 hold/high", hb0 + hi_bad, 0);
    chk(ob0 == 0, "R3 clock while status low", ob0, 0);
    chk(po0 == IC, "R11 init clocks", po0, IC);
    chk(att_cnt == 1, "R6 attempt count", att_cnt, 1);

    defaults(); gaps = 1'b1; run(0);
    chk(ps0 == 1'b1 && by0 == N && bd0 == 0, "R5 stall", bd0, 0);

    defaults(); err_at = 5; err_hold = 30; run(0);
    chk(ps0 == 1'b1, "R7 auto pass", ps0, 1);
    chk(pu0 == 1, "R7 no new pulse", pu0, 1);
    chk(bd0 == 0 && att_cnt == 2, "R6 rewind", att_cnt, 2);

    defaults(); err_at = 5; err_hold = 100000; run(0);
    chk(ps0 == 1'b1 && pu0 == 2, "R8 watchdog pulse", pu0, 2);

    defaults(); no_done = 1'b1; run(0);
    chk(fl0 == 1'b1 && ps0 == 1'b0, "R12 fail", fl0, 1);
    chk(pu0 == MT, "R10 done missing retries", pu0, MT);

    defaults(); init_need = 100; run(0);
    chk(fl0 == 1'b1 && pu0 == MT, "R11 init timeout", pu0, MT);

    defaults(); rel_dly = 100000; run(0);
    chk(fl0 == 1'b1 && pu0 == MT, "R10 status timeout", pu0, MT);
    repeat (50) @(negedge clk);
    chk(fl0 == 1'b1, "R12 fail held", fl0, 1);

    defaults(); run(0);
    chk(ps0 == 1'b1 && fl0 == 1'b0, "R12 restart clears fail", ps0, 1);

    defaults(); err_at = 5; err_hold = 30; run(1);
    chk(ps1 == 1'b1 && pu1 == 2, "R9 manual pulse", pu1, 2);
    chk(bd1 == 0 && ob1 == 0, "R9 data", bd1, 0);

    chk(lo_bad == 0, "R2 pulse width", lo_bad, 0);
    chk(usr_bad == 0, "R13 usr_clk", usr_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule